// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block walks a circular ring of 16-byte receive descriptors in host memory for a network controller. Software sets up the ring through a small register write port: a 64-bit base address split into low and high words, the ring size in bytes, the head and tail indices and an enable bit. The hardware owns every descriptor from head up to, but not including, tail. Software hands a buffer back by writing that descriptor's index to tail.

For each arriving frame the engine reads the descriptor's 8-byte buffer address. It then issues a length-only data transfer to that buffer, which stands in for the packet data write. Next it writes back the descriptor's length and, as the last write, its status and error bytes. Finally it advances head, wrapping to 0 at the end of the ring. A frame that finds the ring full, or the engine disabled, is dropped and counted. A frame longer than one 2048-byte buffer is cut to 2048 bytes and flagged on a sideband output.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset, head_idx is 1, tail is 0, missed_cnt is 0, frm_ready is 1, and neither mem_req nor dat_req is asserted.
- R2: Register writes use reg_addr 0 for base low, 1 for base high, 2 for ring length in bytes, 3 for head, 4 for tail and 5 for control, where bit 0 of control is receive enable. A head write is visible on head_idx in the next cycle.
- R3: A frame is accepted in a cycle where frm_valid and frm_ready are both high. A kept frame first causes one memory read (mem_we 0) at base + 16*head. The 64-bit data returned there is the buffer address.
- R4: After that read, a data transfer is requested with dat_addr equal to the buffer address and dat_len equal to the frame length, capped at 2048.
- R5: Writeback goes to address base + 16*head + 8 in two writes. The first has mem_be 8'h03 and carries the length in bits 15:0. The second and final write has mem_be 8'h30. It carries status in bits 39:32 as 8'h07 (bit 0 done, bit 1 end of packet, bit 2 ignore checksum) and the frame's error code in bits 42:40 (bit 0 CRC/alignment, bit 1 symbol, bit 2 sequence).
- R6: After the status write is acknowledged, head moves to head+1, or to 0 when 16*(head+1) is not below the ring length.
- R7: A frame accepted while head equals tail is dropped. It makes no memory or data request, missed_cnt rises by one, and head is unchanged.
- R8: A frame accepted while enable is 0 is dropped in the same way as in R7.
- R9: A frame longer than 2048 bytes is written back with length 2048 and status 8'h07. len_err is high for exactly the one cycle after its acceptance, and is low for every other frame.
- R10: After software moves tail away from head, the next frame is placed in the descriptor at head again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| frm_valid | input | 1 | Frame arrival valid |
| frm_len | input | 16 | Arriving frame length in bytes |
| frm_err | input | 3 | Arriving frame error code |
| frm_ready | output | 1 | Engine idle, can take a frame |
| mem_req | output | 1 | Descriptor memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Byte address of 8-byte word |
| mem_be | output | 8 | Byte enables for a write |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Memory request complete |
| dat_req | output | 1 | Length-only buffer transfer request |
| dat_addr | output | 64 | Buffer address |
| dat_len | output | 16 | Bytes transferred |
| dat_ack | input | 1 | Transfer complete |
| head_idx | output | 16 | Current head index |
| missed_cnt | output | 16 | Dropped-frame count |
| len_err | output | 1 | Oversize frame pulse |

## Verification
The assertions check on every cycle that head only moves through a register write or an acknowledged status write, and that no length above 2048 reaches memory or the transfer port. They also check that a drop bumps the counter by exactly one and that len_err lasts a single cycle. The bench's scenarios are what show the descriptor addresses, the exact writeback words, and wrapping at the ring length. They also show that a full or disabled ring touches no memory, and that returning buffers through tail resumes reception.

// File: rtl/rx_ring_engine.sv
module rx_ring_engine #(
  parameter int IDXW = 16,
  parameter int BUFB = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        frm_valid,
  input  logic [15:0] frm_len,
  input  logic [2:0]  frm_err,
  output logic        frm_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [63:0] mem_addr,
  output logic [7:0]  mem_be,
  output logic [63:0] mem_wdata,
  input  logic [63:0] mem_rdata,
  input  logic        mem_ack,
  output logic        dat_req,
  output logic [63:0] dat_addr,
  output logic [15:0] dat_len,
  input  logic        dat_ack,
  output logic [IDXW-1:0] head_idx,
  output logic [15:0] missed_cnt,
  output logic        len_err
);
  localparam int PADW = 32 - IDXW - 4;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_DAT, S_WL, S_WS} st_t;
  st_t st;

  logic [31:0] base_lo, base_hi, ring_len;
  logic [IDXW-1:0] head, tail;
  logic        en;
  logic [63:0] buf_addr;
  logic [15:0] cur_len;
  logic [2:0]  cur_err;

  wire [31:0] cur_off  = {{PADW{1'b0}}, head, 4'b0};
  wire [31:0] next_off = cur_off + 32'd16;
  wire [IDXW-1:0] head_nx = (next_off >= ring_len) ? '0 : head + 1'b1;
  wire [63:0] desc_addr = {base_hi, base_lo} + {32'd0, cur_off};
  wire accept = frm_valid && frm_ready;
  wire drop   = !en || (head == tail);
  wire big    = frm_len > 16'(BUFB);

  assign frm_ready = (st == S_IDLE);
  assign mem_req   = (st == S_RD) || (st == S_WL) || (st == S_WS);
  assign mem_we    = (st == S_WL) || (st == S_WS);
  assign mem_addr  = (st == S_RD) ? desc_addr : desc_addr + 64'd8;
  assign mem_be    = (st == S_WS) ? 8'h30 : (st == S_WL) ? 8'h03 : 8'h00;
  assign mem_wdata = (st == S_WS) ? {21'd0, cur_err, 8'h07, 32'd0} : {48'd0, cur_len};
  assign dat_req   = (st == S_DAT);
  assign dat_addr  = buf_addr;
  assign dat_len   = cur_len;
  assign head_idx  = head;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      base_lo <= '0; base_hi <= '0; ring_len <= '0;
      head <= IDXW'(1); tail <= '0; en <= 1'b0;
      buf_addr <= '0; cur_len <= '0; cur_err <= '0;
      missed_cnt <= '0; len_err <= 1'b0;
    end else begin
      len_err <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          if (drop) missed_cnt <= missed_cnt + 1'b1;
          else begin
            cur_len <= big ? 16'(BUFB) : frm_len;
            cur_err <= frm_err;
            len_err <= big;
            st <= S_RD;
          end
        end
        S_RD:  if (mem_ack) begin buf_addr <= mem_rdata; st <= S_DAT; end
        S_DAT: if (dat_ack) st <= S_WL;
        S_WL:  if (mem_ack) st <= S_WS;
        S_WS:  if (mem_ack) begin head <= head_nx; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
      if (reg_wr) begin
        case (reg_addr)
          3'd0: base_lo <= reg_wdata;
          3'd1: base_hi <= reg_wdata;
          3'd2: ring_len <= reg_wdata;
          3'd3: head <= reg_wdata[IDXW-1:0];
          3'd4: tail <= reg_wdata[IDXW-1:0];
          3'd5: en <= reg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  AST_HEAD_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (head != $past(head) && !$past(reg_wr)) |-> $past(mem_req && mem_we && mem_be == 8'h30 && mem_ack)); // R6
  AST_WB_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_be == 8'h03) |-> mem_wdata[15:0] <= 16'(BUFB)); // R9
  AST_DAT_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    dat_req |-> dat_len <= 16'(BUFB)); // R4
  AST_DROP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready && (head == tail) && !reg_wr) |=> (missed_cnt == $past(missed_cnt) + 16'd1) && !mem_req); // R7
  AST_LEN_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> !len_err); // R9
  AST_STATUS_AFTER_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_be == 8'h30) |-> $past(mem_be == 8'h03 && mem_ack)); // R5
endmodule

// File: tb/sim_rx_ring_engine.sv
module sim_rx_ring_engine;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0; logic [2:0] reg_addr = 0; logic [31:0] reg_wdata = 0;
  logic frm_valid = 0; logic [15:0] frm_len = 0; logic [2:0] frm_err = 0;
  logic frm_ready, mem_req, mem_we, mem_ack, dat_req, dat_ack, len_err;
  logic [63:0] mem_addr, mem_wdata, mem_rdata, dat_addr;
  logic [7:0] mem_be;
  logic [15:0] dat_len, head_idx, missed_cnt;
  logic [63:0] mem [0:63];
  int checks = 0, errors = 0, reqs = 0, lerr = 0;
  logic [63:0] last_daddr; logic [15:0] last_dlen;

  always #10 clk = ~clk;

  rx_ring_engine u0 (.*);

  assign mem_ack = mem_req;
  assign dat_ack = dat_req;
  wire [5:0] widx = 6'((mem_addr - 64'h1000) >> 3);
  assign mem_rdata = mem[widx];

  always @(posedge clk) begin
    if (mem_req && mem_we)
      for (int b = 0; b < 8; b++) if (mem_be[b]) mem[widx][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    if (mem_req || dat_req) reqs <= reqs + 1;
    if (len_err) lerr <= lerr + 1;
    if (dat_req) begin last_daddr <= dat_addr; last_dlen <= dat_len; end
  end

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin errors++; $display("FAIL %s actual %h expected %h", r, act, exp); end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic frame(input logic [15:0] l, input logic [2:0] e);
    @(negedge clk); frm_valid = 1; frm_len = l; frm_err = e;
    @(negedge clk); frm_valid = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 head", head_idx, 1); chk("R1 missed", missed_cnt, 0);
    chk("R1 ready", frm_ready, 1); chk("R1 req", {mem_req, dat_req}, 0);
  endtask

  task automatic t_init;
    wreg(0, 32'h1000); wreg(1, 0); wreg(2, 128); wreg(3, 1); wreg(4, 0); wreg(5, 1);
    chk("R2 head write", head_idx, 1);
  endtask

  task automatic t_basic;
    frame(100, 0);
    chk("R3/R4 buffer addr", last_daddr, 64'h8000_0800);
    chk("R4 dat len", last_dlen, 100);
    chk("R5 writeback d1", mem[3], 64'h0000_0007_0000_0064);
    chk("R6 head", head_idx, 2);
    frame(60, 3'b101);
    chk("R5 error code d2", mem[5], 64'h0000_0507_0000_003C);
    chk("R9 no len_err", lerr, 0);
  endtask

  task automatic t_big;
    frame(3000, 0);
    chk("R9 cap len", mem[7], 64'h0000_0007_0000_0800);
    chk("R9 dat len", last_dlen, 16'h0800);
    chk("R9 len_err once", lerr, 1);
  endtask

  task automatic t_wrap_full;
    int r0;
    for (int i = 0; i < 4; i++) frame(16'(10 + i), 0);
    chk("R6 wrap", head_idx, 0);
    chk("R5 d7", mem[15], 64'h0000_0007_0000_000D);
    r0 = reqs;
    frame(77, 0);
    chk("R7 missed", missed_cnt, 1); chk("R7 no access", reqs - r0, 0);
    chk("R7 head kept", head_idx, 0); chk("R7 d0 untouched", mem[1], 0);
  endtask

  task automatic t_return;
    wreg(4, 5);
    frame(33, 3'b010);
    chk("R10 d0 filled", mem[1], 64'h0000_0207_0000_0021);
    chk("R10 buf addr", last_daddr, 64'h8000_0000);
    chk("R10 head", head_idx, 1);
  endtask

  task automatic t_disabled;
    int r0;
    wreg(5, 0); r0 = reqs;
    frame(50, 0);
    chk("R8 missed", missed_cnt, 2); chk("R8 no access", reqs - r0, 0);
    chk("R8 head kept", head_idx, 1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = (i % 2 == 0) ? 64'h8000_0000 + 64'(i / 2) * 2048 : 64'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_init; t_basic; t_big; t_wrap_full; t_return; t_disabled;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule